// File: doc/BRIEF.md
# Modem Status and Interrupt Flag Register

This block sits between the symbol engine of a four-level FSK modem and the host microcontroller. It keeps the status flags that the host polls or reacts to: a buffer-free flag, an interleave-empty flag, a de-interleave overflow flag, a CRC failure flag, a symbol-ready flag with its 2-bit symbol value, and a sticky interrupt request. The modem core reports its events as single-cycle strobes. The host bus supplies command writes, status reads and the current transmit/receive and power-save selections.

Each flag follows its own rules. A normal event sets a flag and raises the interrupt. A RESET command, or any change of the transmit/receive or power-save selection, reinitialises the flags without raising the interrupt. Some flags clear when the host reads the status, and others clear when a new task is written. Fields that have no meaning in the current direction read as zero. A status read captures every field into a holding register on the read cycle, so the host sees the values as they stood before the clear-on-read bits drop.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, the captured status shows buffer-free = 1 and every other field 0, and the interrupt output is 0. The interleave-empty flag is held internally as 1 but reads 0 in receive mode.
- R2: In receive mode (tx_mode = 0), a task-done strobe sets buffer-free and raises the interrupt. In transmit mode the strobe has no effect. A command write whose code is neither NULL (0) nor RESET (1) clears buffer-free, unless a task-done strobe sets it in the same cycle.
- R3: A command write of RESET (code 1), or a change of tx_mode or psave, sets buffer-free and interleave-empty, clears overflow, CRC error, symbol-ready and symbol value, and leaves the interrupt unchanged. This silent reinitialisation overrides every event in the same cycle.
- R4: In transmit mode, a buffer-low strobe sets interleave-empty and raises the interrupt. A command write other than NULL or RESET clears the flag on the next edge, while a NULL write leaves it set. The flag reads 0 in receive mode.
- R5: In receive mode, a command write whose code is one of the four receive-task codes (defaults 2, 3, 4, 5), made while task_late is high, sets overflow and raises the interrupt. A late write with any other code has no effect. Overflow reads 0 in transmit mode.
- R6: In receive mode, a CRC-done strobe loads the CRC error flag with crc_fail and does not raise the interrupt. In transmit mode the strobe is ignored and the flag reads 0.
- R7: A symbol strobe sets symbol-ready in either mode. In receive mode the strobe also loads the symbol value from sym_val. The value field reads 0 in transmit mode.
- R8: On a cycle with stat_rd high, stat_data captures {symval[7:6], symrdy[5], crcerr[4], ovf[3], ibempty[2], buffree[1], irq[0]}, with each field masked for the current mode. Overflow, symbol-ready and the interrupt clear on that edge. Buffer-free, interleave-empty and CRC error are kept.
- R9: The interrupt is sticky. When an interrupt-raising event falls in the same cycle as a status read, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| psave | input | 1 | Power-save selection |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code written |
| stat_rd | input | 1 | Status read strobe |
| task_done | input | 1 | Receive task finished, data placed |
| buf_low | input | 1 | Fewer than two symbols left to transmit |
| task_late | input | 1 | Current receive task write is too late |
| crc_done | input | 1 | CRC check result valid |
| crc_fail | input | 1 | CRC check failed |
| sym_evt | input | 1 | Special symbol received or sent |
| sym_val | input | 2 | Value of received special symbol |
| irq | output | 1 | Interrupt request |
| stat_data | output | 8 | Status captured on the last read |

## Verification
The critical collision is a status read in the same cycle as an interrupt-raising event: a buffer-low strobe in transmit mode, or a late receive-task write. The bench drives both strobes on one clock edge and expects the interrupt to remain high afterwards while the captured byte still holds the pre-read view. A second collision puts a RESET command together with a task-done strobe, where the silent reinitialisation must win and the interrupt must stay low. A sweep over both modes and all event combinations compares each captured byte with a value built from the field rules.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int CMD_W     = 4;
    localparam logic [CMD_W-1:0] CMD_NULL  = 4'd0;
    localparam logic [CMD_W-1:0] CMD_RESET = 4'd1;
    localparam int STAT_W    = 8;

    typedef struct packed {
        logic       irq;
        logic       buf_free;
        logic       ib_empty;
        logic       ovf;
        logic       crc_err;
        logic       sym_rdy;
        logic [1:0] sym_val;
    } flags_t;

    function automatic logic [STAT_W-1:0] pack_view(flags_t f, logic tx);
        return {f.sym_val & {2{~tx}}, f.sym_rdy, f.crc_err & ~tx,
                f.ovf & ~tx, f.ib_empty & tx, f.buf_free, f.irq};
    endfunction
endpackage

// File: rtl/mstat_cmd_dec.sv
module mstat_cmd_dec #(
    parameter int CMD_W = 4,
    parameter int N_RX  = 4,
    parameter logic [N_RX*CMD_W-1:0] RX_CODES = {4'd5, 4'd4, 4'd3, 4'd2}
) (
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             is_reset,
    output logic             is_task,
    output logic             is_rx_task
);
    logic [N_RX-1:0] hit;

    for (genvar i = 0; i < N_RX; i++) begin : g_match
        assign hit[i] = (cmd_code == RX_CODES[i*CMD_W +: CMD_W]);
    end

    assign is_reset   = cmd_wr && (cmd_code == mstat_pkg::CMD_RESET);
    assign is_task    = cmd_wr && (cmd_code != mstat_pkg::CMD_RESET)
                               && (cmd_code != mstat_pkg::CMD_NULL);
    assign is_rx_task = cmd_wr && (|hit);
endmodule

// File: rtl/mstat_mode_watch.sv
module mstat_mode_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_mode,
    input  logic psave,
    output logic changed
);
    typedef struct packed {
        logic tx;
        logic ps;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d.tx = tx_mode;
        mode_d.ps = psave;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q.tx <= tx_mode;
            mode_q.ps <= psave;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign changed = (mode_q != mode_d);
endmodule

// File: rtl/mstat_flags.sv
module mstat_flags
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              silent,
    input  logic              is_task,
    input  logic              is_rx_task,
    input  logic              stat_rd,
    input  logic              task_done,
    input  logic              buf_low,
    input  logic              task_late,
    input  logic              crc_done,
    input  logic              crc_fail,
    input  logic              sym_evt,
    input  logic [1:0]        sym_val,
    output logic              irq,
    output logic [STAT_W-1:0] stat_data
);
    typedef struct packed {
        flags_t            f;
        logic [STAT_W-1:0] rd;
    } st_t;

    st_t  st_d, st_q;
    logic set_bf, set_ib, set_ov, irq_evt;

    always_comb begin
        set_bf  = !tx_mode && task_done;
        set_ib  = tx_mode && buf_low;
        set_ov  = !tx_mode && is_rx_task && task_late;
        irq_evt = !silent && (set_bf || set_ib || set_ov);

        st_d = st_q;
        if (stat_rd) st_d.rd = pack_view(st_q.f, tx_mode);

        if (irq_evt)      st_d.f.irq = 1'b1;
        else if (stat_rd) st_d.f.irq = 1'b0;

        if (silent) begin
            st_d.f.buf_free = 1'b1;
            st_d.f.ib_empty = 1'b1;
            st_d.f.ovf      = 1'b0;
            st_d.f.crc_err  = 1'b0;
            st_d.f.sym_rdy  = 1'b0;
            st_d.f.sym_val  = 2'b00;
        end else begin
            if (set_bf)       st_d.f.buf_free = 1'b1;
            else if (is_task) st_d.f.buf_free = 1'b0;

            if (set_ib)       st_d.f.ib_empty = 1'b1;
            else if (is_task) st_d.f.ib_empty = 1'b0;

            if (set_ov)       st_d.f.ovf = 1'b1;
            else if (stat_rd) st_d.f.ovf = 1'b0;

            if (!tx_mode && crc_done) st_d.f.crc_err = crc_fail;

            if (sym_evt)      st_d.f.sym_rdy = 1'b1;
            else if (stat_rd) st_d.f.sym_rdy = 1'b0;

            if (!tx_mode && sym_evt) st_d.f.sym_val = sym_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.f.irq      <= 1'b0;
            st_q.f.buf_free <= 1'b1;
            st_q.f.ib_empty <= 1'b1;
            st_q.f.ovf      <= 1'b0;
            st_q.f.crc_err  <= 1'b0;
            st_q.f.sym_rdy  <= 1'b0;
            st_q.f.sym_val  <= 2'b00;
            st_q.rd         <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.f.irq;
    assign stat_data = st_q.rd;

    AST_TASK_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (task_done && !tx_mode && !silent) |=> (st_q.f.buf_free && irq)); // R2
    AST_SILENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (silent && !irq) |=> !irq); // R3
    AST_SILENT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        silent |=> (st_q.f.buf_free && st_q.f.ib_empty && !st_q.f.crc_err && !st_q.f.ovf)); // R3
    AST_TASK_CLEARS_IB: assert property (@(posedge clk) disable iff (!rst_n)
        (is_task && !silent && !(tx_mode && buf_low)) |=> !st_q.f.ib_empty); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sym_evt && !set_ov) |=> (!st_q.f.sym_rdy && !st_q.f.ovf)); // R8
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (set_ib || set_ov) && !silent) |=> irq); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd) |=> irq); // R9
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import mstat_pkg::*;
#(
    parameter int N_RX = 4,
    parameter logic [N_RX*CMD_W-1:0] RX_CODES = {4'd5, 4'd4, 4'd3, 4'd2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_mode,
    input  logic             psave,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             stat_rd,
    input  logic             task_done,
    input  logic             buf_low,
    input  logic             task_late,
    input  logic             crc_done,
    input  logic             crc_fail,
    input  logic             sym_evt,
    input  logic [1:0]       sym_val,
    output logic             irq,
    output logic [STAT_W-1:0] stat_data
);
    logic is_reset, is_task, is_rx_task, mode_chg;

    mstat_cmd_dec #(.CMD_W(CMD_W), .N_RX(N_RX), .RX_CODES(RX_CODES)) u_dec (
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .is_reset(is_reset),
        .is_task(is_task), .is_rx_task(is_rx_task)
    );

    mstat_mode_watch u_mode (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .psave(psave),
        .changed(mode_chg)
    );

    mstat_flags u_flags (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode),
        .silent(is_reset || mode_chg), .is_task(is_task),
        .is_rx_task(is_rx_task), .stat_rd(stat_rd), .task_done(task_done),
        .buf_low(buf_low), .task_late(task_late), .crc_done(crc_done),
        .crc_fail(crc_fail), .sym_evt(sym_evt), .sym_val(sym_val),
        .irq(irq), .stat_data(stat_data)
    );
endmodule

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_mode = 1'b0, psave = 1'b0, cmd_wr = 1'b0, stat_rd = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic task_done = 1'b0, buf_low = 1'b0, task_late = 1'b0;
    logic crc_done = 1'b0, crc_fail = 1'b0, sym_evt = 1'b0;
    logic [1:0] sym_val = 2'd0;
    logic irq;
    logic [7:0] stat_data;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .psave(psave),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .stat_rd(stat_rd),
        .task_done(task_done), .buf_low(buf_low), .task_late(task_late),
        .crc_done(crc_done), .crc_fail(crc_fail), .sym_evt(sym_evt),
        .sym_val(sym_val), .irq(irq), .stat_data(stat_data)
    );

    function automatic logic [7:0] mk(logic i, logic bf, logic ib, logic ov,
                                      logic ce, logic sr, logic [1:0] sv);
        return {sv, sr, ce, ov, ib, bf, i};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmd_wr = 0; cmd_code = 0; stat_rd = 0; task_done = 0; buf_low = 0;
        task_late = 0; crc_done = 0; crc_fail = 0; sym_evt = 0; sym_val = 0;
    endtask

    // drive the current inputs for one edge, then return to idle at the next negedge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic cmd(logic [3:0] c, logic late);
        cmd_wr = 1; cmd_code = c; task_late = late; step();
    endtask

    task automatic rd();
        stat_rd = 1; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset view in receive mode
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd();
        check("R1 reset status", stat_data, mk(0,1,0,0,0,0,2'd0));

        // R4 switch to transmit: silent init shows ib_empty
        tx_mode = 1; step();
        rd();
        check("R4 tx after mode change", stat_data, mk(0,1,1,0,0,0,2'd0));
        check("R3 mode change no irq", {7'd0, irq}, 8'h00);

        // R4 NULL write leaves ib_empty set
        cmd(4'd0, 0);
        rd();
        check("R4 NULL keeps ib_empty", stat_data, mk(0,1,1,0,0,0,2'd0));

        // R9 buffer-low event together with read: set wins
        buf_low = 1; stat_rd = 1; step();
        check("R9 set wins irq", {7'd0, irq}, 8'h01);
        check("R8 pre-clear capture", stat_data, mk(0,1,1,0,0,0,2'd0));
        rd();
        check("R9 read after event", stat_data, mk(1,1,1,0,0,0,2'd0));
        check("R9 irq cleared", {7'd0, irq}, 8'h00);

        // back to receive; R5 late receive task
        tx_mode = 0; step();
        cmd(4'd3, 1);
        check("R5 overflow irq", {7'd0, irq}, 8'h01);
        rd();
        check("R5 overflow view", stat_data, mk(1,0,0,1,0,0,2'd0));
        rd();
        check("R8 overflow cleared", stat_data, mk(0,0,0,0,0,0,2'd0));
        cmd(4'd6, 1);
        rd();
        check("R5 other code ignored", stat_data, mk(0,0,0,0,0,0,2'd0));

        // R3 RESET with task_done in same cycle: silent wins
        cmd_wr = 1; cmd_code = 4'd1; task_done = 1; step();
        check("R3 reset wins irq", {7'd0, irq}, 8'h00);
        rd();
        check("R3 reset wins view", stat_data, mk(0,1,0,0,0,0,2'd0));

        // R3 psave toggle reinitialises silently
        cmd(4'd7, 0);
        psave = 1; step();
        rd();
        check("R3 psave change", stat_data, mk(0,1,0,0,0,0,2'd0));
        psave = 0; step();

        // sweep both modes over all event patterns
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 128; k++) begin
                logic td, bl, sy, cd, cf;
                logic [1:0] sv;
                td = k[0]; bl = k[1]; sy = k[2]; cd = k[3]; cf = k[4];
                sv = 2'(k >> 5);
                tx_mode = m[0]; step();
                cmd(4'd1, 0);
                cmd(4'd6, 0);
                rd();
                task_done = td; buf_low = bl; sym_evt = sy; crc_done = cd;
                crc_fail = cf; sym_val = sv; step();
                rd();
                if (m == 0)
                    check("R2 R6 R7 rx sweep", stat_data,
                          mk(td, td, 0, 0, cd & cf, sy, sy ? sv : 2'd0));
                else
                    check("R2 R4 R6 R7 tx sweep", stat_data,
                          mk(bl, 0, bl, 0, 0, sy, 2'd0));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule